// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block sits beside the issue queue of an out-of-order core and decides when each in-flight load or store may be handed on for issue. It keeps a small table of live memory operations and barriers, each tagged with a sequence number and a thread. A new operation waits on a producer, or it does not. The producer is the youngest active barrier of the right kind when one is outstanding. Otherwise it is whatever store sequence number an external dependence predictor returns for the operation's PC. An operation is sent out only when two conditions hold: its register operands are ready, and its memory producer has completed.

The pipeline drives one command per cycle on a single command bus: insert, non-speculative insert, barrier insert, register-ready, non-speculative-ready, reschedule, replay, complete, complete-barrier or squash. Ready operations leave on a registered strobe at most one per cycle. When several are waiting, the one that became ready first leaves first. Inserted stores and squashes are passed on to the predictor one cycle later. Four statistics counters record inserted loads and stores, and the loads and stores that had to wait.

Top module: `mem_dep_tracker`

## Requirements
- R1: A full memory barrier (kind code 2) makes loads (kind 0) and stores (kind 1) inserted after it wait until it completes. A write barrier (kind 3) makes only later stores wait.
- R2: On a normal insert, an active barrier of the matching kind takes the place of the predictor's producer. Without one, the producer is the value on `pred_seq` for the PC on `pred_pc`.
- R3: A producer of zero, or one whose sequence number is not in the table, means no dependency. The operation then leaves as soon as its registers are ready, including at insert time.
- R4: An operation with a live producer does not leave, even if its registers are ready. When the producer completes, each of its dependents leaves if its registers are ready and otherwise becomes memory-ready.
- R5: A register-ready command sends an operation out only if that operation is already memory-ready.
- R6: A non-speculative insert makes no dependence check. The operation leaves only after a non-speculative-ready command.
- R7: Completing a barrier frees its entry and releases its dependents. It clears the load-barrier or store-barrier flag only when that flag's recorded sequence number equals the completing one.
- R8: Every inserted store is reported one cycle later with its PC, sequence number and thread. The counters count inserted loads and stores, and separately the normal inserts of each type that had to wait.
- R9: A squash removes every entry of the given thread younger than the given sequence number. It drops them from the replay set and forwards the squash one cycle later. Survivors that waited on a removed entry are released.
- R10: A replay sends out every rescheduled operation, in the order in which they were rescheduled. If the named operation was not rescheduled, `replay_miss` pulses for one cycle.
- R11: At most one operation leaves per cycle. An operation made ready by the command at clock edge k appears on `rdy_valid` after edge k+1, and ready operations leave oldest first, in the order of the events that made them ready.
- R12: `tbl_full` is high when every entry is occupied. An insert of any type while it is high is dropped and changes neither the table nor any counter.
- R13: After reset the table is empty, both barrier flags are clear, every output strobe is low and every counter is zero.

Command codes on `cmd_op`: 0 none, 1 insert, 2 non-speculative insert, 3 barrier insert, 4 register-ready, 5 non-speculative-ready, 6 reschedule, 7 replay, 8 complete, 9 complete-barrier, 10 squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 4 | Command code, one command per cycle |
| cmd_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| cmd_seq | input | SEQ_W | Sequence number of the operation, or the squash boundary |
| cmd_tid | input | TID_W | Thread of the operation or of the squash |
| cmd_pc | input | PC_W | PC of the operation being inserted |
| cmd_regs_rdy | input | 1 | Registers already ready at insert |
| pred_pc | output | PC_W | PC looked up in the dependence predictor |
| pred_seq | input | SEQ_W | Predicted producing store, zero for none |
| tbl_full | output | 1 | Every entry is occupied; inserts are dropped |
| rdy_valid | output | 1 | One operation leaves this cycle |
| rdy_seq | output | SEQ_W | Sequence number of the leaving operation |
| rdy_tid | output | TID_W | Thread of the leaving operation |
| replay_miss | output | 1 | Replay named an operation that was not rescheduled |
| st_rpt_valid | output | 1 | A store was inserted in the previous cycle |
| st_rpt_pc | output | PC_W | PC of the reported store |
| st_rpt_seq | output | SEQ_W | Sequence number of the reported store |
| st_rpt_tid | output | TID_W | Thread of the reported store |
| sq_fwd_valid | output | 1 | Squash forwarded to the predictor |
| sq_fwd_seq | output | SEQ_W | Forwarded squash boundary |
| sq_fwd_tid | output | TID_W | Forwarded squash thread |
| cnt_ins_ld | output | CNT_W | Inserted loads |
| cnt_ins_st | output | CNT_W | Inserted stores |
| cnt_wait_ld | output | CNT_W | Loads that waited on a producer |
| cnt_wait_st | output | CNT_W | Stores that waited on a producer |

## Verification
Some properties are checked on every cycle. A pending operation reached by the normal path is both register-ready and memory-ready. The selector never picks more than one entry, and never one that is not pending. A full table never grows on an insert. The store-barrier flag only drops on the completion of the barrier it records. The forwarding strobes and the replay-miss pulse are only ever caused by the matching command. Other behaviour shows only in the bench's scenarios: which operations leave and in what order, the release of dependents when a store or barrier completes, the sequence-number match on barrier completion, the squash across threads together with the replay set, and the counter totals. The bench sweeps every combination of operation type, barrier type and register readiness.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_INS      = 4'd1,
    OP_INS_NS   = 4'd2,
    OP_INS_BAR  = 4'd3,
    OP_REGS     = 4'd4,
    OP_NS_RDY   = 4'd5,
    OP_RESCHED  = 4'd6,
    OP_REPLAY   = 4'd7,
    OP_DONE     = 4'd8,
    OP_DONE_BAR = 4'd9,
    OP_SQUASH   = 4'd10
  } mdt_op_e;

  typedef enum logic [1:0] {
    K_LOAD    = 2'd0,
    K_STORE   = 2'd1,
    K_FULLBAR = 2'd2,
    K_WRBAR   = 2'd3
  } mdt_kind_e;

  // Sequence numbers never wrap inside a run, so plain magnitude is age.
  function automatic logic seq_younger(input logic [63:0] a, input logic [63:0] b);
    return a > b;
  endfunction

  // Ready-event stamps: a smaller stamp became ready earlier.
  function automatic logic stamp_earlier(input logic [63:0] a, input logic [63:0] b);
    return a < b;
  endfunction

  function automatic logic is_mem_kind(input logic [1:0] k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction

endpackage

// File: rtl/mdt_cam.sv
module mdt_cam #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = 3
) (
  input  logic [N-1:0]        live,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        key,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && live[i] && tags[i] == key) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mdt_oldest_pick.sv
module mdt_oldest_pick #(
  parameter int N  = 8,
  parameter int SW = 16,
  parameter int IW = 3
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][SW-1:0] stamp,
  output logic                 found,
  output logic [IW-1:0]        idx,
  output logic [N-1:0]         onehot
);
  import mdt_pkg::*;
  logic [SW-1:0] best;
  always_comb begin
    found  = 1'b0;
    idx    = '0;
    best   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || stamp_earlier(64'(stamp[i]), 64'(best)))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = stamp[i];
      end
    end
    onehot = '0;
    if (found) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/mdt_stat_ctr.sv
module mdt_stat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (inc) value <= value + 1'b1;
  end
endmodule

// File: rtl/mem_dep_tracker.sv
module mem_dep_tracker #(
  parameter int ENTRIES = 8,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 1,
  parameter int PC_W    = 16,
  parameter int STAMP_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cmd_op,
  input  logic [1:0]       cmd_kind,
  input  logic [SEQ_W-1:0] cmd_seq,
  input  logic [TID_W-1:0] cmd_tid,
  input  logic [PC_W-1:0]  cmd_pc,
  input  logic             cmd_regs_rdy,
  output logic [PC_W-1:0]  pred_pc,
  input  logic [SEQ_W-1:0] pred_seq,
  output logic             tbl_full,
  output logic             rdy_valid,
  output logic [SEQ_W-1:0] rdy_seq,
  output logic [TID_W-1:0] rdy_tid,
  output logic             replay_miss,
  output logic             st_rpt_valid,
  output logic [PC_W-1:0]  st_rpt_pc,
  output logic [SEQ_W-1:0] st_rpt_seq,
  output logic [TID_W-1:0] st_rpt_tid,
  output logic             sq_fwd_valid,
  output logic [SEQ_W-1:0] sq_fwd_seq,
  output logic [TID_W-1:0] sq_fwd_tid,
  output logic [CNT_W-1:0] cnt_ins_ld,
  output logic [CNT_W-1:0] cnt_ins_st,
  output logic [CNT_W-1:0] cnt_wait_ld,
  output logic [CNT_W-1:0] cnt_wait_st
);
  import mdt_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Entry table
  logic [ENTRIES-1:0]              tv, tregs, tmem, tns, twait, tpend, tresch;
  logic [ENTRIES-1:0][SEQ_W-1:0]   tseq;
  logic [ENTRIES-1:0][TID_W-1:0]   ttid;
  logic [ENTRIES-1:0][1:0]         tkind;
  logic [ENTRIES-1:0][IDX_W-1:0]   twidx;
  logic [ENTRIES-1:0][STAMP_W-1:0] tstamp;

  // Barrier tracking
  logic             ldb_act, stb_act;
  logic [SEQ_W-1:0] ldb_seq, stb_seq;
  logic [STAMP_W-1:0] stamp_ctr;

  mdt_op_e   op;
  mdt_kind_e kind;
  assign op   = mdt_op_e'(cmd_op);
  assign kind = mdt_kind_e'(cmd_kind);

  // Named internal events
  logic             c_hit, p_hit, f_found, dep, ins_ok, ins_req;
  logic [IDX_W-1:0] c_idx, p_idx, f_idx;
  logic [SEQ_W-1:0] prod_seq;
  logic [ENTRIES-1:0] kill, release_v, pick_req, pick_oh;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             ins_new_pend, ins_is_store;

  assign pred_pc = cmd_pc;

  mdt_cam #(.N(ENTRIES), .W(SEQ_W), .IW(IDX_W)) u_cmd_cam (
    .live(tv), .tags(tseq), .key(cmd_seq), .hit(c_hit), .idx(c_idx));

  always_comb begin
    if (kind == K_LOAD && ldb_act)       prod_seq = ldb_seq;
    else if (kind == K_STORE && stb_act) prod_seq = stb_seq;
    else                                 prod_seq = pred_seq;
  end

  mdt_cam #(.N(ENTRIES), .W(SEQ_W), .IW(IDX_W)) u_prod_cam (
    .live(tv), .tags(tseq), .key(prod_seq), .hit(p_hit), .idx(p_idx));

  assign dep = (prod_seq != '0) && p_hit;

  always_comb begin
    f_found = 1'b0;
    f_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!f_found && !tv[i]) begin
        f_found = 1'b1;
        f_idx   = IDX_W'(i);
      end
    end
  end

  assign tbl_full = &tv;
  assign ins_req  = ((op == OP_INS || op == OP_INS_NS) && is_mem_kind(cmd_kind)) ||
                    (op == OP_INS_BAR && !is_mem_kind(cmd_kind));
  assign ins_ok   = ins_req && f_found;
  assign ins_is_store = ins_ok && op != OP_INS_BAR && kind == K_STORE;
  assign ins_new_pend = (op == OP_INS) && !dep && cmd_regs_rdy;

  // Entries removed this cycle, and survivors whose producer goes away
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      kill[i] = 1'b0;
      if ((op == OP_DONE || op == OP_DONE_BAR) && c_hit && c_idx == IDX_W'(i))
        kill[i] = 1'b1;
      if (op == OP_SQUASH && tv[i] && ttid[i] == cmd_tid &&
          seq_younger(64'(tseq[i]), 64'(cmd_seq)))
        kill[i] = 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++)
      release_v[i] = tv[i] && twait[i] && !kill[i] && kill[twidx[i]];
  end

  assign pick_req = tpend & ~kill;

  mdt_oldest_pick #(.N(ENTRIES), .SW(STAMP_W), .IW(IDX_W)) u_pick (
    .req(pick_req), .stamp(tstamp), .found(pick_found), .idx(pick_idx), .onehot(pick_oh));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tv <= '0; tregs <= '0; tmem <= '0; tns <= '0; twait <= '0;
      tpend <= '0; tresch <= '0;
      tseq <= '0; ttid <= '0; tkind <= '0; twidx <= '0; tstamp <= '0;
      ldb_act <= 1'b0; stb_act <= 1'b0; ldb_seq <= '0; stb_seq <= '0;
      stamp_ctr <= '0;
      rdy_valid <= 1'b0; rdy_seq <= '0; rdy_tid <= '0;
      replay_miss <= 1'b0;
      st_rpt_valid <= 1'b0; st_rpt_pc <= '0; st_rpt_seq <= '0; st_rpt_tid <= '0;
      sq_fwd_valid <= 1'b0; sq_fwd_seq <= '0; sq_fwd_tid <= '0;
    end else begin
      if (op != OP_NOP) stamp_ctr <= stamp_ctr + 1'b1;

      // Output stage: one operation per cycle
      rdy_valid <= pick_found;
      rdy_seq   <= tseq[pick_idx];
      rdy_tid   <= ttid[pick_idx];
      if (pick_found) tpend[pick_idx] <= 1'b0;

      // Removal, release and replay across the table
      for (int i = 0; i < ENTRIES; i++) begin
        if (kill[i]) begin
          tv[i] <= 1'b0; tpend[i] <= 1'b0; tresch[i] <= 1'b0; twait[i] <= 1'b0;
        end
        if (release_v[i]) begin
          twait[i] <= 1'b0;
          tmem[i]  <= 1'b1;
          if (tregs[i]) begin
            tpend[i]  <= 1'b1;
            tstamp[i] <= stamp_ctr;
          end
        end
        if (op == OP_REPLAY && tresch[i]) begin
          tpend[i]  <= 1'b1;
          tresch[i] <= 1'b0;
        end
      end

      // Single-entry commands
      if (op == OP_REGS && c_hit) begin
        tregs[c_idx] <= 1'b1;
        if (tmem[c_idx]) begin
          tpend[c_idx]  <= 1'b1;
          tstamp[c_idx] <= stamp_ctr;
        end
      end
      if (op == OP_NS_RDY && c_hit) begin
        tpend[c_idx]  <= 1'b1;
        tstamp[c_idx] <= stamp_ctr;
      end
      if (op == OP_RESCHED && c_hit) begin
        tresch[c_idx] <= 1'b1;
        tstamp[c_idx] <= stamp_ctr;
      end

      if (ins_ok) begin
        tv[f_idx]     <= 1'b1;
        tseq[f_idx]   <= cmd_seq;
        ttid[f_idx]   <= cmd_tid;
        tkind[f_idx]  <= cmd_kind;
        tregs[f_idx]  <= cmd_regs_rdy;
        tns[f_idx]    <= (op == OP_INS_NS);
        twait[f_idx]  <= (op == OP_INS) && dep;
        twidx[f_idx]  <= p_idx;
        tmem[f_idx]   <= (op == OP_INS) && !dep;
        tpend[f_idx]  <= ins_new_pend;
        tresch[f_idx] <= 1'b0;
        tstamp[f_idx] <= stamp_ctr;
      end

      // Barrier flags
      if (ins_ok && op == OP_INS_BAR) begin
        if (kind == K_FULLBAR) begin
          ldb_act <= 1'b1; ldb_seq <= cmd_seq;
        end
        stb_act <= 1'b1; stb_seq <= cmd_seq;
      end
      if (op == OP_DONE_BAR && c_hit) begin
        if (ldb_act && ldb_seq == cmd_seq) ldb_act <= 1'b0;
        if (stb_act && stb_seq == cmd_seq) stb_act <= 1'b0;
      end

      replay_miss  <= (op == OP_REPLAY) && !(c_hit && tresch[c_idx]);
      st_rpt_valid <= ins_is_store;
      st_rpt_pc    <= cmd_pc;
      st_rpt_seq   <= cmd_seq;
      st_rpt_tid   <= cmd_tid;
      sq_fwd_valid <= (op == OP_SQUASH);
      sq_fwd_seq   <= cmd_seq;
      sq_fwd_tid   <= cmd_tid;
    end
  end

  // Statistics
  logic inc_il, inc_is, inc_wl, inc_ws;
  assign inc_il = ins_ok && op != OP_INS_BAR && kind == K_LOAD;
  assign inc_is = ins_is_store;
  assign inc_wl = ins_ok && op == OP_INS && dep && kind == K_LOAD;
  assign inc_ws = ins_ok && op == OP_INS && dep && kind == K_STORE;

  mdt_stat_ctr #(.W(CNT_W)) u_c_il (.clk(clk), .rst_n(rst_n), .inc(inc_il), .value(cnt_ins_ld));
  mdt_stat_ctr #(.W(CNT_W)) u_c_is (.clk(clk), .rst_n(rst_n), .inc(inc_is), .value(cnt_ins_st));
  mdt_stat_ctr #(.W(CNT_W)) u_c_wl (.clk(clk), .rst_n(rst_n), .inc(inc_wl), .value(cnt_wait_ld));
  mdt_stat_ctr #(.W(CNT_W)) u_c_ws (.clk(clk), .rst_n(rst_n), .inc(inc_ws), .value(cnt_wait_st));

  // Assertions
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
      // R5: the normal path only pends an operation that is ready on both counts
      assert_ready_needs_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tpend[g]) && $past(cmd_op) != OP_REPLAY && $past(cmd_op) != OP_NS_RDY)
          |-> (tmem[g] && tregs[g]));
    end
  endgenerate

  assert_one_pick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  assert_pick_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> tpend[pick_idx]);

  assert_full_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_full && (cmd_op == OP_INS || cmd_op == OP_INS_NS || cmd_op == OP_INS_BAR))
      |=> ($countones(tv) == $past($countones(tv))));

  assert_miss_from_replay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    replay_miss |-> ($past(cmd_op) == OP_REPLAY));

  assert_store_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_rpt_valid |-> ($past(cmd_kind) == K_STORE));

  assert_squash_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_fwd_valid |-> ($past(cmd_op) == OP_SQUASH));

  assert_bar_clear_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_act) |-> ($past(cmd_op) == OP_DONE_BAR && $past(cmd_seq) == $past(stb_seq)));

endmodule

// File: tb/mem_dep_tracker_tb.sv
module mem_dep_tracker_tb;
  import mdt_pkg::*;

  localparam int ENTRIES = 8;
  localparam int SEQ_W = 16, TID_W = 1, PC_W = 16, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_kind = '0;
  logic [SEQ_W-1:0] cmd_seq = '0, pred_seq = '0;
  logic [TID_W-1:0] cmd_tid = '0;
  logic [PC_W-1:0] cmd_pc = '0;
  logic cmd_regs_rdy = 1'b0;
  logic [PC_W-1:0] pred_pc;
  logic tbl_full, rdy_valid, replay_miss, st_rpt_valid, sq_fwd_valid;
  logic [SEQ_W-1:0] rdy_seq, st_rpt_seq, sq_fwd_seq;
  logic [TID_W-1:0] rdy_tid, st_rpt_tid, sq_fwd_tid;
  logic [PC_W-1:0] st_rpt_pc;
  logic [CNT_W-1:0] cnt_ins_ld, cnt_ins_st, cnt_wait_ld, cnt_wait_st;

  always #5 clk = ~clk;

  mem_dep_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_kind(cmd_kind), .cmd_seq(cmd_seq),
    .cmd_tid(cmd_tid), .cmd_pc(cmd_pc), .cmd_regs_rdy(cmd_regs_rdy), .pred_pc(pred_pc),
    .pred_seq(pred_seq), .tbl_full(tbl_full), .rdy_valid(rdy_valid), .rdy_seq(rdy_seq),
    .rdy_tid(rdy_tid), .replay_miss(replay_miss), .st_rpt_valid(st_rpt_valid),
    .st_rpt_pc(st_rpt_pc), .st_rpt_seq(st_rpt_seq), .st_rpt_tid(st_rpt_tid),
    .sq_fwd_valid(sq_fwd_valid), .sq_fwd_seq(sq_fwd_seq), .sq_fwd_tid(sq_fwd_tid),
    .cnt_ins_ld(cnt_ins_ld), .cnt_ins_st(cnt_ins_st), .cnt_wait_ld(cnt_wait_ld),
    .cnt_wait_st(cnt_wait_st));

  int checks = 0, errors = 0;
  int ev_seq [0:1023];
  int ev_n = 0, miss_n = 0, st_n = 0, sq_n = 0;
  int st_seq_l = 0, st_pc_l = 0, st_tid_l = 0, sq_seq_l = 0, sq_tid_l = 0;
  int e_il = 0, e_is = 0, e_wl = 0, e_ws = 0;

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy_valid) begin
        if (ev_n < 1024) ev_seq[ev_n] = int'(rdy_seq);
        ev_n++;
      end
      if (replay_miss) miss_n++;
      if (st_rpt_valid) begin
        st_n++; st_seq_l = int'(st_rpt_seq); st_pc_l = int'(st_rpt_pc); st_tid_l = int'(st_rpt_tid);
      end
      if (sq_fwd_valid) begin
        sq_n++; sq_seq_l = int'(sq_fwd_seq); sq_tid_l = int'(sq_fwd_tid);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input mdt_op_e op, input logic [1:0] kind, input int seq, input int tid,
                      input int pc, input bit regs, input int pred);
    cmd_op = op; cmd_kind = kind; cmd_seq = SEQ_W'(seq); cmd_tid = TID_W'(tid);
    cmd_pc = PC_W'(pc); cmd_regs_rdy = regs; pred_seq = SEQ_W'(pred);
    @(posedge clk); #1;
    cmd_op = OP_NOP;
  endtask

  task automatic ins(input logic [1:0] kind, input int seq, input int tid, input bit regs,
                     input int pred, input bit ns, input bit wait_exp, input bit ok_exp);
    send(ns ? OP_INS_NS : OP_INS, kind, seq, tid, 16'h100 + seq, regs, pred);
    if (ok_exp) begin
      if (kind == K_LOAD) e_il++; else e_is++;
      if (wait_exp && !ns) begin
        if (kind == K_LOAD) e_wl++; else e_ws++;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cleanup();
    idle(3);
    send(OP_SQUASH, K_LOAD, 0, 0, 0, 0, 0);
    send(OP_SQUASH, K_LOAD, 0, 1, 0, 0, 0);
    idle(2);
  endtask

  function automatic bit seen(input int m, input int s);
    for (int k = m; k < ev_n && k < 1024; k++) if (ev_seq[k] == s) return 1'b1;
    return 1'b0;
  endfunction

  int m, sq0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R13 reset state
    chk(rdy_valid == 0 && replay_miss == 0 && st_rpt_valid == 0, "R13 strobes", rdy_valid, 0);
    chk(tbl_full == 0, "R13 tbl_full", tbl_full, 0);
    chk(cnt_ins_ld == 0 && cnt_ins_st == 0 && cnt_wait_ld == 0 && cnt_wait_st == 0,
        "R13 counters", cnt_ins_ld + cnt_ins_st + cnt_wait_ld + cnt_wait_st, 0);

    // R11 latency and R3 no producer
    ins(K_LOAD, 1, 0, 1, 0, 0, 0, 1);
    chk(rdy_valid == 0, "R11 not before edge k+1", rdy_valid, 0);
    @(posedge clk); #1;
    chk(rdy_valid == 1 && rdy_seq == 1, "R11 out at edge k+1", rdy_seq, 1);
    idle(2);
    // R5 register-ready path
    m = ev_n;
    ins(K_LOAD, 2, 0, 0, 0, 0, 0, 1);
    idle(3);
    chk(ev_n == m, "R5 no regs no issue", ev_n - m, 0);
    send(OP_REGS, K_LOAD, 2, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 1 && seen(m, 2), "R5 regs-ready issues", ev_n - m, 1);

    // R4 predicted store dependency
    m = ev_n;
    ins(K_STORE, 3, 0, 0, 0, 0, 0, 1);
    ins(K_LOAD, 4, 0, 1, 3, 0, 1, 1);
    ins(K_LOAD, 5, 0, 0, 3, 0, 1, 1);
    idle(3);
    chk(ev_n == m, "R4 dependent held", ev_n - m, 0);
    send(OP_DONE, K_STORE, 3, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 1 && seen(m, 4), "R4 wake regs-ready dependent", ev_n - m, 1);
    send(OP_REGS, K_LOAD, 5, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 2 && seen(m, 5), "R4 woken becomes memory-ready", ev_n - m, 2);

    // R3 absent producer
    m = ev_n;
    ins(K_LOAD, 6, 0, 1, 77, 0, 0, 1);
    idle(3);
    chk(ev_n == m + 1 && seen(m, 6), "R3 absent producer", ev_n - m, 1);
    cleanup();

    // R1 full barrier
    m = ev_n;
    send(OP_INS_BAR, K_FULLBAR, 10, 0, 0, 0, 0);
    ins(K_LOAD, 11, 0, 1, 0, 0, 1, 1);
    ins(K_STORE, 12, 0, 1, 0, 0, 1, 1);
    idle(3);
    chk(ev_n == m, "R1 full barrier holds both", ev_n - m, 0);
    send(OP_DONE_BAR, K_FULLBAR, 10, 0, 0, 0, 0);
    idle(4);
    chk(ev_n == m + 2 && seen(m, 11) && seen(m, 12), "R1 full barrier release", ev_n - m, 2);
    m = ev_n;
    ins(K_LOAD, 13, 0, 1, 0, 0, 0, 1);
    idle(3);
    chk(ev_n == m + 1, "R7 flag cleared after match", ev_n - m, 1);
    cleanup();

    // R1 write barrier
    m = ev_n;
    send(OP_INS_BAR, K_WRBAR, 20, 0, 0, 0, 0);
    ins(K_LOAD, 21, 0, 1, 0, 0, 0, 1);
    ins(K_STORE, 22, 0, 1, 0, 0, 1, 1);
    idle(3);
    chk(ev_n == m + 1 && seen(m, 21), "R1 write barrier passes loads", ev_n - m, 1);
    send(OP_DONE_BAR, K_WRBAR, 20, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 2 && seen(m, 22), "R1 write barrier releases store", ev_n - m, 2);
    cleanup();

    // R2 barrier overrides predictor, loads still use predictor
    m = ev_n;
    send(OP_INS_BAR, K_WRBAR, 25, 0, 0, 0, 0);
    ins(K_STORE, 26, 0, 1, 0, 0, 1, 1);
    ins(K_LOAD, 27, 0, 1, 26, 0, 1, 1);
    idle(3);
    chk(ev_n == m, "R2 barrier producer used", ev_n - m, 0);
    send(OP_DONE_BAR, K_WRBAR, 25, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 1 && seen(m, 26), "R2 load waits on predicted store", ev_n - m, 1);
    send(OP_DONE, K_STORE, 26, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 2 && seen(m, 27), "R2 predicted store completes", ev_n - m, 2);
    cleanup();

    // R7 sequence-number match on barrier completion
    m = ev_n;
    send(OP_INS_BAR, K_FULLBAR, 30, 0, 0, 0, 0);
    send(OP_INS_BAR, K_WRBAR, 31, 0, 0, 0, 0);
    send(OP_DONE_BAR, K_FULLBAR, 30, 0, 0, 0, 0);
    ins(K_STORE, 32, 0, 1, 0, 0, 1, 1);
    ins(K_LOAD, 33, 0, 1, 0, 0, 0, 1);
    idle(3);
    chk(ev_n == m + 1 && seen(m, 33), "R7 store flag kept, load flag cleared", ev_n - m, 1);
    send(OP_DONE_BAR, K_WRBAR, 31, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 2 && seen(m, 32), "R7 second barrier releases", ev_n - m, 2);
    cleanup();

    // R6 non-speculative, R8 store report
    m = ev_n;
    ins(K_LOAD, 40, 0, 1, 0, 1, 0, 1);
    idle(3);
    send(OP_REGS, K_LOAD, 40, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m, "R6 no issue before ns-ready", ev_n - m, 0);
    send(OP_NS_RDY, K_LOAD, 40, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m + 1 && seen(m, 40), "R6 ns-ready issues", ev_n - m, 1);
    sq0 = st_n;
    ins(K_STORE, 41, 1, 0, 0, 1, 0, 1);
    idle(1);
    chk(st_n == sq0 + 1 && st_seq_l == 41 && st_tid_l == 1, "R8 store report seq/tid", st_seq_l, 41);
    chk(st_pc_l == 16'h100 + 41, "R8 store report pc", st_pc_l, 16'h100 + 41);
    cleanup();

    // R10 replay order and miss
    ins(K_LOAD, 50, 0, 1, 0, 0, 0, 1);
    ins(K_LOAD, 51, 0, 1, 0, 0, 0, 1);
    ins(K_LOAD, 52, 0, 1, 0, 0, 0, 1);
    idle(4);
    m = ev_n; sq0 = miss_n;
    send(OP_RESCHED, K_LOAD, 52, 0, 0, 0, 0);
    send(OP_RESCHED, K_LOAD, 50, 0, 0, 0, 0);
    idle(2);
    chk(ev_n == m, "R10 reschedule alone does not issue", ev_n - m, 0);
    send(OP_REPLAY, K_LOAD, 50, 0, 0, 0, 0);
    idle(4);
    chk(ev_n == m + 2, "R10 replay count", ev_n - m, 2);
    chk(ev_seq[m] == 52 && ev_seq[m + 1] == 50, "R10 replay order", ev_seq[m], 52);
    chk(miss_n == sq0, "R10 no miss", miss_n - sq0, 0);
    send(OP_REPLAY, K_LOAD, 51, 0, 0, 0, 0);
    idle(3);
    chk(miss_n == sq0 + 1 && ev_n == m + 2, "R10 miss flagged", miss_n - sq0, 1);
    cleanup();

    // R9 squash by thread
    m = ev_n; sq0 = sq_n;
    ins(K_STORE, 60, 1, 0, 0, 0, 0, 1);
    ins(K_LOAD, 61, 1, 1, 60, 0, 1, 1);
    ins(K_LOAD, 62, 1, 1, 60, 0, 1, 1);
    ins(K_LOAD, 63, 0, 0, 0, 0, 0, 1);
    send(OP_RESCHED, K_LOAD, 62, 1, 0, 0, 0);
    send(OP_RESCHED, K_LOAD, 63, 0, 0, 0, 0);
    send(OP_SQUASH, K_LOAD, 60, 1, 0, 0, 0);
    idle(1);
    chk(sq_n == sq0 + 1 && sq_seq_l == 60 && sq_tid_l == 1, "R9 squash forwarded", sq_seq_l, 60);
    send(OP_DONE, K_STORE, 60, 1, 0, 0, 0);
    idle(3);
    chk(ev_n == m, "R9 squashed dependents gone", ev_n - m, 0);
    sq0 = miss_n;
    send(OP_REPLAY, K_LOAD, 63, 0, 0, 0, 0);
    idle(4);
    chk(ev_n == m + 1 && seen(m, 63), "R9 replay set pruned", ev_n - m, 1);
    chk(miss_n == sq0, "R9 surviving thread replay no miss", miss_n - sq0, 0);
    cleanup();

    // R12 full table
    for (int i = 0; i < ENTRIES; i++) ins(K_LOAD, 70 + i, 0, 0, 0, 0, 0, 1);
    chk(tbl_full == 1, "R12 full asserted", tbl_full, 1);
    m = ev_n;
    ins(K_LOAD, 90, 0, 1, 0, 0, 0, 0);
    idle(3);
    send(OP_NS_RDY, K_LOAD, 90, 0, 0, 0, 0);
    idle(3);
    chk(ev_n == m, "R12 dropped insert never issues", ev_n - m, 0);
    chk(cnt_ins_ld == CNT_W'(e_il), "R12 counter unchanged by drop", cnt_ins_ld, e_il);
    send(OP_DONE, K_LOAD, 70, 0, 0, 0, 0);
    chk(tbl_full == 0, "R12 full clears", tbl_full, 0);
    cleanup();

    // Sweep: op kind x barrier kind x register readiness (R1 R3 R4)
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < 3; b++) begin
        for (int r = 0; r < 2; r++) begin
          bit w;
          w = (b == 1) || (b == 2 && k == 1);
          m = ev_n;
          if (b == 1) send(OP_INS_BAR, K_FULLBAR, 100, 0, 0, 0, 0);
          if (b == 2) send(OP_INS_BAR, K_WRBAR, 100, 0, 0, 0, 0);
          ins(k == 0 ? K_LOAD : K_STORE, 101, 0, r[0], 0, 0, w, 1);
          idle(3);
          chk(ev_n - m == ((!w && r == 1) ? 1 : 0), "R1 sweep at insert", ev_n - m, (!w && r == 1));
          if (b != 0) begin
            send(OP_DONE_BAR, b == 1 ? K_FULLBAR : K_WRBAR, 100, 0, 0, 0, 0);
            idle(3);
            chk(ev_n - m == (r == 1 ? 1 : 0), "R4 sweep after barrier", ev_n - m, r);
          end
          cleanup();
        end
      end
    end

    // R8 counters
    chk(cnt_ins_ld == CNT_W'(e_il), "R8 inserted loads", cnt_ins_ld, e_il);
    chk(cnt_ins_st == CNT_W'(e_is), "R8 inserted stores", cnt_ins_st, e_is);
    chk(cnt_wait_ld == CNT_W'(e_wl), "R8 waiting loads", cnt_wait_ld, e_wl);
    chk(cnt_wait_st == CNT_W'(e_ws), "R8 waiting stores", cnt_wait_st, e_ws);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule